// File: doc/BRIEF.md
# SRAM Chip-Enable Write-Protect Gate

This block sits between a memory controller's four active-low chip-enable lines and up to four SRAM devices. While the supply is healthy, it routes the enable lines to the SRAMs without a clock stage in the path. How it routes them depends on a bank arrangement. That arrangement is captured from a three-state mode pin each time power is restored. In the arrangements with fewer banks, the third and fourth enable pins act as address bits that pick the SRAM.

An external comparator supplies a power-fail flag, which the block synchronises. When the flag rises, every output not in use at that moment is driven inactive at once. An output that is mid-access stays active until its enable input is released, or until a grace deadline counted in clock cycles runs out, whichever comes first. After that the output stays inactive for the rest of the failure and for a recovery interval after the flag clears. The grace length, the recovery length and the synchroniser depth are parameters.

Top module: `ce_wp_gate`

## Requirements
- R1: In the four-bank arrangement (mode pin driven low, captured as mode 0), with power good, output k equals input k for k = 0..3.
- R2: In the two-bank arrangement (mode pin driven high, captured as mode 1), inputs 0 and 1 are the active-low bank enables, and input 2 is address A (1 = high). Bank 0 drives output 0 when A = 0 and output 1 when A = 1. Bank 1 drives output 2 when A = 0 and output 3 when A = 1. Input 3 has no effect.
- R3: In the single-bank arrangement (mode pin floating, captured as mode 2), input 0 is the active-low enable. The code {input 3, input 2} selects the output index 0..3 that it drives. Input 1 has no effect.
- R4: The arrangement is captured only at the cycle in which the synchronised power-fail flag is first seen low after a failure or after reset. Mode pin changes at any other time have no effect. The arrangement after reset is mode 0.
- R5: In mode 2, at most one output is low at any time.
- R6: An output whose decoded enable is inactive when the failure is detected is driven high, and it stays high for the whole failure.
- R7: An output whose decoded enable is active when the failure is detected stays low until that enable goes inactive. From the next cycle on, it is high.
- R8: An output held low across a failure is forced high no later than GRACE_CYC cycles after the detection edge.
- R9: Once an output has been driven high during a failure, it stays high even if its enable becomes active again.
- R10: After the synchronised flag clears, all outputs stay high for REC_CYC cycles. A new failure inside that window restarts the whole sequence.
- R11: While power is good and recovery has ended, the outputs follow the inputs in the same cycle, with no clock edge in between.
- R12: During reset and right after it, the block treats power as failed and all outputs are high.
- R13: The block acts on the power-fail flag SYNC_STAGES clock edges after the flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_fail_i | input | 1 | Power-fail flag from the external comparator, high = supply out of tolerance |
| mode_lvl_i | input | 1 | Level of the mode pin when it is driven (0 = mode 0, 1 = mode 1) |
| mode_hiz_i | input | 1 | High when the mode pin is sensed floating (selects mode 2) |
| ce_n_i | input | 4 | Active-low enable inputs; bits 2 and 3 act as address A and B in modes 1 and 2 |
| ce_n_o | output | 4 | Active-low enables to the four SRAMs |

## Verification
The hardest case to reach is an access that straddles a failure. The enable must already be low when the synchronised flag arrives, and then it must either be released before the grace deadline or held past it. After release, a fresh access attempt has to come before power returns. Directed sequences build these cases in every arrangement: they hold one decoded channel low, raise the flag, and then release or re-assert the enable on chosen cycles. Randomised flag toggling, some of it landing inside the recovery window, covers the interleavings of capture, release and restart. In every case the outputs are compared each cycle against a reference model in the bench.

// File: rtl/ce_wp_pkg.sv
package ce_wp_pkg;
  localparam int unsigned N_CE = 4;

  typedef enum logic [1:0] {
    BANK_4X1 = 2'd0,
    BANK_2X2 = 2'd1,
    BANK_1X4 = 2'd2
  } bank_mode_e;

  typedef enum logic [1:0] {
    ST_FAIL = 2'd0,
    ST_REC  = 2'd1,
    ST_GOOD = 2'd2
  } pwr_st_e;
endpackage

// File: rtl/ce_wp_sync.sv
module ce_wp_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ce_wp_decode.sv
module ce_wp_decode
  import ce_wp_pkg::*;
(
  input  bank_mode_e      mode_i,
  input  logic [N_CE-1:0] ce_n_i,
  output logic [N_CE-1:0] req_o
);
  logic       addr_a;
  logic [1:0] code;

  assign addr_a = ce_n_i[2];
  assign code   = {ce_n_i[3], ce_n_i[2]};

  always_comb begin
    req_o = '0;
    unique case (mode_i)
      BANK_2X2: begin
        req_o[0] = !ce_n_i[0] && !addr_a;
        req_o[1] = !ce_n_i[0] &&  addr_a;
        req_o[2] = !ce_n_i[1] && !addr_a;
        req_o[3] = !ce_n_i[1] &&  addr_a;
      end
      BANK_1X4: begin
        for (int k = 0; k < N_CE; k++)
          req_o[k] = !ce_n_i[0] && (code == 2'(k));
      end
      default: req_o = ~ce_n_i;
    endcase
  end
endmodule

// File: rtl/ce_wp_hold.sv
module ce_wp_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic release_i,
  input  logic req_i,
  output logic hold_o
);
  logic hold_q;

  // an access survives only while its enable stays active and grace remains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= 1'b0;
    else if (capture_i) hold_q <= req_i;
    else                hold_q <= hold_q && req_i && !release_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/ce_wp_ctrl.sv
module ce_wp_ctrl
  import ce_wp_pkg::*;
#(
  parameter int unsigned GRACE_CYC = 300,
  parameter int unsigned REC_CYC   = 25_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fail_i,
  input  logic       mode_lvl_i,
  input  logic       mode_hiz_i,
  output pwr_st_e    st_o,
  output logic [$clog2(((GRACE_CYC > REC_CYC) ? GRACE_CYC : REC_CYC) + 1)-1:0] cnt_o,
  output bank_mode_e mode_o,
  output logic       capture_o,
  output logic       release_o
);
  localparam int unsigned CNT_MAX = (GRACE_CYC > REC_CYC) ? GRACE_CYC : REC_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] GRACE_LAST = CNT_W'(GRACE_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(REC_CYC - 1);

  pwr_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  bank_mode_e       mode_q, mode_d;
  bank_mode_e       mode_pin;

  assign mode_pin = mode_hiz_i ? BANK_1X4 : (mode_lvl_i ? BANK_2X2 : BANK_4X1);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    unique case (st_q)
      ST_FAIL: begin
        if (!fail_i) begin
          st_d   = ST_REC;
          cnt_d  = '0;
          mode_d = mode_pin;
        end else if (cnt_q != GRACE_LAST) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_REC: begin
        if (fail_i) begin
          st_d  = ST_FAIL;
          cnt_d = '0;
        end else if (cnt_q == REC_LAST) begin
          st_d  = ST_GOOD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (fail_i) begin
          st_d  = ST_FAIL;
          cnt_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_FAIL;
      cnt_q  <= '0;
      mode_q <= BANK_4X1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign st_o      = st_q;
  assign cnt_o     = cnt_q;
  assign mode_o    = mode_q;
  assign capture_o = (st_q == ST_GOOD) && fail_i;
  assign release_o = (st_q != ST_FAIL) || (cnt_q == GRACE_LAST) || !fail_i;
endmodule

// File: rtl/ce_wp_gate.sv
module ce_wp_gate
  import ce_wp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GRACE_CYC   = 300,
  parameter int unsigned REC_CYC     = 25_000_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_fail_i,
  input  logic            mode_lvl_i,
  input  logic            mode_hiz_i,
  input  logic [N_CE-1:0] ce_n_i,
  output logic [N_CE-1:0] ce_n_o
);
  localparam int unsigned CNT_MAX = (GRACE_CYC > REC_CYC) ? GRACE_CYC : REC_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic             fail_s;
  pwr_st_e          st;
  logic [CNT_W-1:0] cnt;
  bank_mode_e       mode;
  logic             capture, release_g;
  logic [N_CE-1:0]  req, hold;

  ce_wp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwr_fail_i),
    .q_o   (fail_s)
  );

  ce_wp_ctrl #(.GRACE_CYC(GRACE_CYC), .REC_CYC(REC_CYC)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fail_i    (fail_s),
    .mode_lvl_i(mode_lvl_i),
    .mode_hiz_i(mode_hiz_i),
    .st_o      (st),
    .cnt_o     (cnt),
    .mode_o    (mode),
    .capture_o (capture),
    .release_o (release_g)
  );

  ce_wp_decode u_dec (
    .mode_i(mode),
    .ce_n_i(ce_n_i),
    .req_o (req)
  );

  generate
    for (genvar k = 0; k < N_CE; k++) begin : g_ch
      ce_wp_hold u_hold (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .capture_i(capture),
        .release_i(release_g),
        .req_i    (req[k]),
        .hold_o   (hold[k])
      );
    end
  endgenerate

  // enables stay combinational while good; only held accesses pass during a failure
  always_comb begin
    unique case (st)
      ST_GOOD: ce_n_o = ~req;
      ST_FAIL: ce_n_o = ~(req & hold);
      default: ce_n_o = '1;
    endcase
  end
endmodule

// File: rtl/ce_wp_gate_chk.sv
module ce_wp_gate_chk
  import ce_wp_pkg::*;
#(
  parameter int unsigned GRACE_CYC = 300,
  parameter int unsigned CNT_W     = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input pwr_st_e          st_i,
  input logic [CNT_W-1:0] cnt_i,
  input bank_mode_e       mode_i,
  input logic [N_CE-1:0]  ce_n_o
);
  p_onehot_bank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == BANK_1X4) |-> ($countones(~ce_n_o) <= 1));

  p_no_reenable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_FAIL && $past(st_i) == ST_FAIL) |-> ((~ce_n_o & $past(ce_n_o)) == '0));

  p_rec_inhibit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_REC) |-> (ce_n_o == '1));

  p_grace_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_FAIL && cnt_i == CNT_W'(GRACE_CYC - 1)) |=> (ce_n_o == '1));

  p_mode_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_GOOD && $past(st_i) == ST_GOOD) |-> $stable(mode_i));
endmodule

bind ce_wp_gate ce_wp_gate_chk #(.GRACE_CYC(GRACE_CYC), .CNT_W(CNT_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .st_i  (st),
  .cnt_i (cnt),
  .mode_i(mode),
  .ce_n_o(ce_n_o)
);

// File: tb/sim_ce_wp_gate.sv
`timescale 1ns/1ps
module sim_ce_wp_gate;
  localparam int SYNC  = 2;
  localparam int GRACE = 6;
  localparam int REC   = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pf = 1'b1;
  logic       m_lvl = 1'b0;
  logic       m_hiz = 1'b0;
  logic [3:0] ce_n = 4'hf;
  logic [3:0] out_n;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R12";

  always #2.5 clk = ~clk;

  ce_wp_gate #(.SYNC_STAGES(SYNC), .GRACE_CYC(GRACE), .REC_CYC(REC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_fail_i(pf), .mode_lvl_i(m_lvl),
    .mode_hiz_i(m_hiz), .ce_n_i(ce_n), .ce_n_o(out_n)
  );

  // reference model: 0 = failed, 1 = recovering, 2 = good
  logic [SYNC-1:0] r_pipe;
  int r_phase, r_age, r_mode;
  logic [3:0] r_keep;

  function automatic logic [3:0] want_req(int md, logic [3:0] c);
    logic [3:0] r = 4'h0;
    if (md == 1) begin
      r[0] = !c[0] && !c[2]; r[1] = !c[0] && c[2];
      r[2] = !c[1] && !c[2]; r[3] = !c[1] && c[2];
    end else if (md == 2) begin
      if (!c[0]) r[{c[3], c[2]}] = 1'b1;
    end else r = ~c;
    return r;
  endfunction

  function automatic logic [3:0] want_out();
    logic [3:0] r = want_req(r_mode, ce_n);
    if (r_phase == 2) return ~r;
    if (r_phase == 0) return ~(r & r_keep);
    return 4'hf;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_pipe <= '1; r_phase <= 0; r_age <= 0; r_mode <= 0; r_keep <= 4'h0;
    end else begin
      logic f;
      logic [3:0] rq;
      f  = r_pipe[SYNC-1];
      rq = want_req(r_mode, ce_n);
      r_pipe <= {r_pipe[SYNC-2:0], pf};
      case (r_phase)
        0: begin
          r_keep <= (f && r_age < GRACE - 1) ? (r_keep & rq) : 4'h0;
          if (!f) begin
            r_phase <= 1; r_age <= 0; r_mode <= m_hiz ? 2 : (m_lvl ? 1 : 0);
          end else if (r_age < GRACE - 1) r_age <= r_age + 1;
        end
        1: begin
          r_keep <= 4'h0;
          if (f) begin r_phase <= 0; r_age <= 0; end
          else if (r_age == REC - 1) begin r_phase <= 2; r_age <= 0; end
          else r_age <= r_age + 1;
        end
        default: begin
          if (f) begin r_phase <= 0; r_age <= 0; r_keep <= rq; end
          else r_keep <= 4'h0;
        end
      endcase
    end
  end

  task automatic chk();
    logic [3:0] e = want_out();
    total++;
    if (out_n !== e) begin
      bad++;
      $display("FAIL %s t=%0t out=%h exp=%h", tag, $time, out_n, e);
    end
    if (r_mode == 2) begin
      total++;
      if ($countones(~out_n) > 1) begin
        bad++;
        $display("FAIL R5 t=%0t out=%h exp=at most one low", $time, out_n);
      end
    end
  endtask

  task automatic step(logic p, logic [3:0] c);
    @(negedge clk);
    pf = p; ce_n = c;
    #1 chk();
  endtask

  task automatic restore(logic lvl, logic hiz);
    m_lvl = lvl; m_hiz = hiz;
    tag = "R10";
    for (int i = 0; i < SYNC + REC + 3; i++) step(1'b0, 4'hf);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1 tag = "R12"; chk();
    rst_n = 1'b1;
    step(1'b1, 4'h0);
    step(1'b1, 4'h5);

    restore(1'b0, 1'b0);
    tag = "R1";
    for (int i = 0; i < 40; i++) step(1'b0, 4'($urandom));
    tag = "R11";
    for (int i = 0; i < 8; i++) step(1'b0, 4'(1 << (i % 4)) ^ 4'hf);
    tag = "R4";
    m_hiz = 1'b1;
    for (int i = 0; i < 20; i++) step(1'b0, 4'($urandom));
    m_lvl = 1'b1;
    for (int i = 0; i < 10; i++) step(1'b0, 4'($urandom));

    // access in flight on channel 0, released early, then retried
    step(1'b0, 4'he);
    tag = "R13";
    for (int i = 0; i < SYNC; i++) step(1'b1, 4'he);
    tag = "R7";
    step(1'b1, 4'he);
    step(1'b1, 4'he);
    step(1'b1, 4'hf);
    step(1'b1, 4'hf);
    tag = "R9";
    for (int i = 0; i < 6; i++) step(1'b1, 4'h0);
    tag = "R6";
    for (int i = 0; i < 4; i++) step(1'b1, 4'($urandom));

    // recovery interrupted by a new failure, then mode 1
    m_hiz = 1'b0; m_lvl = 1'b1;
    tag = "R10";
    for (int i = 0; i < SYNC + 4; i++) step(1'b0, 4'h0);
    for (int i = 0; i < SYNC + 2; i++) step(1'b1, 4'h0);
    restore(1'b1, 1'b0);
    tag = "R2";
    for (int i = 0; i < 40; i++) step(1'b0, 4'($urandom));

    // access held past the grace deadline: bank 1, A=1 -> output 3
    step(1'b0, 4'b0101);
    tag = "R8";
    for (int i = 0; i < SYNC + GRACE + 4; i++) step(1'b1, 4'b0101);
    tag = "R9";
    step(1'b1, 4'b1111);
    for (int i = 0; i < 4; i++) step(1'b1, 4'b0100);

    restore(1'b0, 1'b1);
    tag = "R3";
    for (int i = 0; i < 40; i++) step(1'b0, 4'($urandom));
    step(1'b0, 4'b1000);
    tag = "R8";
    for (int i = 0; i < SYNC + GRACE + 2; i++) step(1'b1, 4'b1000);

    restore(1'b0, 1'b0);
    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      logic p = ($urandom % 16) < 3 ? !pf : pf;
      if ($urandom % 8 == 0) begin m_lvl = 1'($urandom); m_hiz = 1'($urandom); end
      step(p, ($urandom % 4 == 0) ? 4'($urandom) : ce_n);
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog t=%0t out=%h exp=finished", $time, out_n);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule